// File: doc/BRIEF.md
# Three-Channel Transfer Request Arbiter

This block decides which of three serial audio channels may use a shared DMA engine next. Each channel raises its request line when it has data to move. When no grant is outstanding, the arbiter looks at the active requests and picks one according to a 2-bit policy input. It then holds that grant until the engine reports that the transfer is done, or until the granted channel withdraws its request. One instance covers one group of three channels. A second group of three is served by a second instance.

The policy input chooses between two fixed rankings and a rotating scheme. Both fixed rankings put channel 0 first. They differ only in the order of channels 1 and 2. In the rotating scheme the channel served most recently falls to the lowest rank. One policy code is reserved. While that code is applied, the arbiter issues no grants and raises an error flag. The grant output works as a valid/ready pair. `gnt_valid` with `gnt`/`gnt_idx` form the offer, and `done` is the ready side that ends it. Until `done` arrives, the grant and its index stay frozen, and no other channel can take the engine. A `done` that arrives while nothing is granted has no effect.

Top module: `chan_req_arbiter`

## Requirements
- R1: After reset, `gnt` is 000, `gnt_valid` is 0 and `mode_err` is 0. The rotation pointer starts at channel 2, so the first rotating search begins at channel 0.
- R2: With `mode` = 2'b00, channel 0 wins over channel 1, and channel 1 wins over channel 2.
- R3: With `mode` = 2'b01, channel 0 wins over channel 2, and channel 2 wins over channel 1.
- R4: With `mode` = 2'b11, the search starts at the channel after the one granted last, in any mode, and wraps from 2 to 0. The last-granted channel has the lowest rank.
- R5: If `mode` = 2'b10 on a clock edge where no grant is held, no grant is issued and `mode_err` reads 1 after that edge. The first idle edge with a legal mode clears it.
- R6: A grant stays unchanged until an edge where `done` is 1 or the granted channel's request is 0. After that edge `gnt_valid` is 0. The next decision is made on the edge after that, so a new grant appears two edges after `done` at the earliest.
- R7: A change of `mode` while a grant is held changes neither the grant nor `mode_err` until the grant is released.
- R8: `gnt` is one-hot or all zeros. `gnt_valid` is 1 exactly when `gnt` is non-zero. While valid, `gnt_idx` is the binary index of the set bit (bit i of `gnt` is channel i).
- R9: A decision grants only a channel whose request was 1 on the deciding edge. With no request active, no grant is made.
- R10: `done` while no grant is held is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | NUM_CH | Request line per channel, bit i = channel i |
| mode | input | 2 | Policy: 00 fixed 0>1>2, 01 fixed 0>2>1, 10 reserved, 11 rotating |
| done | input | 1 | Transfer complete; releases the held grant |
| gnt | output | NUM_CH | One-hot grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_idx | output | IDX_W | Index of the granted channel |
| mode_err | output | 1 | Reserved policy code seen at the last idle decision |

## Verification
A corrupted rotation pointer does not show up while a grant is held. It appears at the next rotating decision with at least two channels requesting, where the wrong channel is granted on the deciding edge. A stuck busy state shows at once: the grant fails to drop on the edge after `done`, or no new grant follows. A wrong error state shows within one idle edge, as `mode_err` disagrees with a reserved or legal code that was applied.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic [1:0] {
    POL_FIX_ASC  = 2'b00,
    POL_FIX_TAIL = 2'b01,
    POL_RSVD     = 2'b10,
    POL_ROTATE   = 2'b11
  } arb_policy_e;
endpackage

// File: rtl/arb_fixed_pick.sv
module arb_fixed_pick #(
  parameter int NUM_CH    = 3,
  parameter bit TAIL_DESC = 1'b0
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] pick
);
  // rank 0 is always channel 0; the rest run ascending or descending
  function automatic int rank_to_ch(input int rank);
    if (rank == 0)     return 0;
    else if (TAIL_DESC) return NUM_CH - rank;
    else                return rank;
  endfunction

  always_comb begin
    pick = '0;
    // walk from lowest rank to highest; the last hit wins
    for (int k = NUM_CH - 1; k >= 0; k--) begin
      if (req[rank_to_ch(k)]) begin
        pick = '0;
        pick[rank_to_ch(k)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
  parameter int NUM_CH = 3,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  input  logic [IDX_W-1:0]  last_idx,
  output logic [NUM_CH-1:0] pick
);
  function automatic int wrap_ch(input int base, input int off);
    int s;
    s = base + off;
    if (s >= NUM_CH) s = s - NUM_CH;
    return s;
  endfunction

  always_comb begin
    pick = '0;
    // offset NUM_CH is the last-served channel itself (lowest rank)
    for (int off = NUM_CH; off >= 1; off--) begin
      if (req[wrap_ch(int'(last_idx), off)]) begin
        pick = '0;
        pick[wrap_ch(int'(last_idx), off)] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/arb_onehot_enc.sv
module arb_onehot_enc #(
  parameter int NUM_CH = 3,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] onehot,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end
endmodule

// File: rtl/chan_req_arbiter.sv
module chan_req_arbiter
  import arb_pkg::*;
#(
  parameter int NUM_CH = 3,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [1:0]        mode,
  input  logic              done,
  output logic [NUM_CH-1:0] gnt,
  output logic              gnt_valid,
  output logic [IDX_W-1:0]  gnt_idx,
  output logic              mode_err
);
  logic [NUM_CH-1:0] fixed_pick [2];
  logic [NUM_CH-1:0] rr_pick;
  logic [NUM_CH-1:0] sel;
  logic [IDX_W-1:0]  sel_idx;

  logic              busy_q;
  logic [NUM_CH-1:0] gnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_q;
  logic              err_q;
  logic              release_now;

  // variant 0: ascending tail, variant 1: descending tail
  for (genvar v = 0; v < 2; v++) begin : g_fixed
    arb_fixed_pick #(
      .NUM_CH   (NUM_CH),
      .TAIL_DESC(v == 1)
    ) u_fixed (
      .req (req),
      .pick(fixed_pick[v])
    );
  end

  arb_rr_pick #(.NUM_CH(NUM_CH)) u_rr (
    .req     (req),
    .last_idx(last_q),
    .pick    (rr_pick)
  );

  always_comb begin
    unique case (arb_policy_e'(mode))
      POL_FIX_ASC:  sel = fixed_pick[0];
      POL_FIX_TAIL: sel = fixed_pick[1];
      POL_ROTATE:   sel = rr_pick;
      default:      sel = '0;
    endcase
  end

  arb_onehot_enc #(.NUM_CH(NUM_CH)) u_enc (
    .onehot(sel),
    .idx   (sel_idx)
  );

  // completion or withdrawal of the granted request ends the grant
  assign release_now = done | ~req[idx_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      gnt_q  <= '0;
      idx_q  <= '0;
      last_q <= IDX_W'(NUM_CH - 1);
      err_q  <= 1'b0;
    end else if (busy_q) begin
      if (release_now) begin
        busy_q <= 1'b0;
        gnt_q  <= '0;
      end
    end else begin
      err_q <= (arb_policy_e'(mode) == POL_RSVD);
      if (|sel) begin
        busy_q <= 1'b1;
        gnt_q  <= sel;
        idx_q  <= sel_idx;
        last_q <= sel_idx;
      end
    end
  end

  assign gnt       = gnt_q;
  assign gnt_valid = busy_q;
  assign gnt_idx   = idx_q;
  assign mode_err  = err_q;
endmodule

// File: rtl/arb_checker.sv
module arb_checker #(
  parameter int NUM_CH = 3,
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] req,
  input logic [1:0]        mode,
  input logic              done,
  input logic [NUM_CH-1:0] gnt,
  input logic              gnt_valid,
  input logic [IDX_W-1:0]  gnt_idx,
  input logic              mode_err
);
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  a_r8_valid_match: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid == (gnt != '0));

  a_r8_idx: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid |-> gnt[gnt_idx]);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !done && ((req & gnt) != '0)) |=> ($stable(gnt) && gnt_valid));

  a_r6_release: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && done) |=> !gnt_valid);

  a_r9_requested: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gnt_valid) |-> (($past(req) & gnt) != '0));

  a_r5_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
    mode_err |-> !gnt_valid);

  a_r7_err_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && $past(gnt_valid)) |-> $stable(mode_err));

  a_r2_ch0_first: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gnt_valid) && $past(mode) == 2'b00 && $past(req[0])) |-> gnt[0]);
endmodule

bind chan_req_arbiter arb_checker #(.NUM_CH(NUM_CH)) u_chk (.*);

// File: tb/chan_req_arbiter_bench.sv
`timescale 1ns/1ps
module chan_req_arbiter_bench;
  localparam int NUM_CH = 3;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] req = '0;
  logic [1:0]        mode = 2'b00;
  logic              done = 1'b0;
  logic [NUM_CH-1:0] gnt;
  logic              gnt_valid;
  logic [IDX_W-1:0]  gnt_idx;
  logic              mode_err;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  chan_req_arbiter #(.NUM_CH(NUM_CH)) u_chan_req_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .mode(mode), .done(done),
    .gnt(gnt), .gnt_valid(gnt_valid), .gnt_idx(gnt_idx), .mode_err(mode_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_grant(input string tag, input logic [2:0] exp);
    check(gnt == exp, tag, int'(gnt), int'(exp));
    check(gnt_valid == (exp != 0), {tag, " valid"}, int'(gnt_valid), int'(exp != 0));
    if (exp != 0) begin
      int ei;
      ei = exp[0] ? 0 : (exp[1] ? 1 : 2);
      check(int'(gnt_idx) == ei, {tag, " idx"}, int'(gnt_idx), ei);
    end
  endtask

  // drive at a negedge, let one posedge pass, sample at the next negedge
  task automatic decide(input logic [1:0] m, input logic [2:0] r);
    mode = m; req = r;
    @(negedge clk);
  endtask

  task automatic release_grant(input string tag);
    done = 1'b1; req = '0;
    @(negedge clk);
    check(gnt_valid == 1'b0, tag, int'(gnt_valid), 0);
    done = 1'b0;
  endtask

  task automatic t_reset;
    check_grant("R1 reset", 3'b000);
    check(mode_err == 1'b0, "R1 reset err", int'(mode_err), 0);
  endtask

  task automatic t_fixed_asc;
    decide(2'b00, 3'b111); check_grant("R2 all", 3'b001);
    release_grant("R6 release");
    decide(2'b00, 3'b110); check_grant("R2 1 over 2", 3'b010);
    release_grant("R6 release");
    decide(2'b00, 3'b100); check_grant("R2 only 2", 3'b100);
    release_grant("R6 release");
  endtask

  task automatic t_fixed_tail;
    decide(2'b01, 3'b110); check_grant("R3 2 over 1", 3'b100);
    release_grant("R6 release");
    decide(2'b01, 3'b111); check_grant("R3 all", 3'b001);
    release_grant("R6 release");
  endtask

  task automatic t_rotate;
    // last granted is channel 0 here
    decide(2'b11, 3'b111); check_grant("R4 step1", 3'b010);
    release_grant("R6 release");
    decide(2'b11, 3'b111); check_grant("R4 step2", 3'b100);
    release_grant("R6 release");
    decide(2'b11, 3'b111); check_grant("R4 wrap", 3'b001);
    release_grant("R6 release");
    decide(2'b11, 3'b101); check_grant("R4 skip", 3'b100);
    release_grant("R6 release");
    decide(2'b11, 3'b011); check_grant("R4 wrap skip", 3'b001);
    release_grant("R6 release");
  endtask

  task automatic t_reserved;
    decide(2'b10, 3'b111);
    check_grant("R5 no grant", 3'b000);
    check(mode_err == 1'b1, "R5 err set", int'(mode_err), 1);
    repeat (3) @(negedge clk);
    check_grant("R5 still none", 3'b000);
    decide(2'b00, 3'b111);
    check(mode_err == 1'b0, "R5 err clear", int'(mode_err), 0);
    check_grant("R5 legal again", 3'b001);
    release_grant("R6 release");
  endtask

  task automatic t_hold;
    decide(2'b00, 3'b010); check_grant("R6 held start", 3'b010);
    mode = 2'b10; req = 3'b111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_grant("R6 held", 3'b010);
      check(mode_err == 1'b0, "R7 err frozen", int'(mode_err), 0);
    end
    done = 1'b1;
    @(negedge clk);
    check_grant("R6 drop after done", 3'b000);
    done = 1'b0; mode = 2'b00; req = 3'b001;
    @(negedge clk);
    check_grant("R6 regrant gap", 3'b001);
    release_grant("R6 release");
  endtask

  task automatic t_withdraw;
    decide(2'b00, 3'b011); check_grant("R6 pre withdraw", 3'b001);
    req = 3'b010;
    @(negedge clk);
    check_grant("R6 withdraw", 3'b000);
    @(negedge clk);
    check_grant("R9 next requester", 3'b010);
    release_grant("R6 release");
  endtask

  task automatic t_idle_done;
    mode = 2'b00; req = '0; done = 1'b1;
    repeat (2) @(negedge clk);
    check_grant("R10 done idle", 3'b000);
    check_grant("R9 no req", 3'b000);
    done = 1'b0;
    decide(2'b00, 3'b100); check_grant("R10 after idle done", 3'b100);
    release_grant("R6 release");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_fixed_asc;
    t_fixed_tail;
    t_rotate;
    t_reserved;
    t_hold;
    t_withdraw;
    t_idle_done;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule